// File: doc/BRIEF.md
# Packed-BCD Adjust and Sign-Extend Unit

This unit sits beside the accumulator of a 16-bit processor datapath. It runs one of three operations per transfer. The first corrects a byte after a packed-decimal addition. The second corrects a byte after a packed-decimal subtraction. The third fills a high register with copies of the sign bit of the 16-bit accumulator. Instruction decode, the register file and the preceding add or subtract are handled elsewhere. The unit receives the low accumulator byte, the accumulator word, an operation code and the current status flags. It returns a 16-bit result and an updated flag vector.

Each decimal correction has two steps, and they run in a fixed order. The first step looks at the low nibble and the incoming auxiliary carry, and may apply a correction of 06h. The second step then examines the byte that the first step produced, together with the incoming carry, and may apply a correction of 60h. An addition adds both corrections and a subtraction subtracts them, with the byte wrapping modulo 256.

Both ends of the unit use valid/ready handshakes:
- An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high.
- The registered result appears with `out_valid` on the following cycle.
- The result stays in place until a clock edge where `out_valid` and `out_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in the same cycle.
- A downstream stall therefore stalls the input after at most one accepted transfer.

Top module: `bcd_sext_unit`

## Requirements
- R1: Addition adjust (op 0). If the low nibble of `acc_lo` is above 9, or the auxiliary carry flag in (bit 2) is 1, the byte is increased by 06h modulo 256 and auxiliary carry out is 1. Otherwise the byte is unchanged and auxiliary carry out is 0.
- R2: Addition adjust, second step. If the byte left by the first step is above 9Fh, or the carry flag in (bit 0) is 1, it is increased by 60h modulo 256 and carry out is 1. Otherwise carry out is 0. The adjusted byte is placed in `result[7:0]`, and `result[15:8]` is 00h.
- R3: Subtraction adjust (op 1). The same two tests are made in the same order, each on the byte as it stands at that step. The unit subtracts 06h and then 60h modulo 256 instead of adding them, and sets auxiliary carry out and carry out the same way as for the addition adjust.
- R4: Sign extension (op 2 or op 3). `result` is 0000h when `acc_word` is below 8000h, and FFFFh otherwise.
- R5: Sign extension leaves every flag unchanged: `flag_out` equals `flag_in`. The flag bit positions are carry 0, parity 1, auxiliary carry 2, zero 3, sign 4, overflow 5.
- R6: For both adjusts, the flags are set from the final adjusted byte. Parity is 1 when that byte holds an even number of ones. Sign is bit 7 of the byte. Zero is 1 when the byte is 00h. Overflow is driven to 0, but its value is left undefined.
- R7: `out_valid` rises exactly one clock after an accepted input and falls after a transfer out when no new input is accepted in the same cycle.
- R8: While `out_valid` is high and `out_ready` is low, `result` and `flag_out` hold steady and `in_ready` is low.
- R9: A synchronous reset clears `out_valid`, `result` and `flag_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer request |
| in_ready | output | 1 | Unit can accept an input this cycle |
| op | input | 2 | 0 addition adjust, 1 subtraction adjust, 2 or 3 sign extension |
| acc_lo | input | 8 | Low accumulator byte |
| acc_word | input | 16 | Full accumulator word |
| flag_in | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 16 | Adjusted byte (zero-extended) or sign fill word |
| flag_out | output | 6 | Updated flags, same bit layout as flag_in |

## Verification
The result is a single registered stage, so any wrong internal value shows at the ports on the first cycle that `out_valid` is high after the offending input. The reference model runs the two correction steps in order. A design that tests the second condition on the original byte, or that does not clear a carry when its condition is false, therefore gives a mismatch on a specific byte/flag combination, and every such combination is driven for both adjusts. A stuck or leaky output register shows during back-pressure within one cycle, either as a result that changes while the output is stalled or as `in_ready` rising too early.

// File: rtl/adjx_pkg.sv
package adjx_pkg;
  localparam int FLAG_W = 6;
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef enum logic [1:0] {
    OP_ADD_ADJ  = 2'd0,
    OP_SUB_ADJ  = 2'd1,
    OP_SEXT     = 2'd2,
    OP_SEXT_ALT = 2'd3
  } op_e;
endpackage

// File: rtl/bcd_correct.sv
module bcd_correct #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              subtract,
  input  logic              af_in,
  input  logic              cf_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              af_out,
  output logic              cf_out
);
  localparam int NIB_W = 4;
  localparam logic [BYTE_W-1:0] LO_FIX   = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_FIX   = BYTE_W'(6 << (BYTE_W - NIB_W));
  localparam logic [BYTE_W-1:0] HI_LIMIT = BYTE_W'((10 << (BYTE_W - NIB_W)) - 1);

  logic [BYTE_W-1:0] stage1;
  logic              lo_hit;
  logic              hi_hit;

  // step one: low digit correction
  always_comb begin
    lo_hit = (byte_in[NIB_W-1:0] > NIB_W'(9)) || af_in;
    if (lo_hit) stage1 = subtract ? (byte_in - LO_FIX) : (byte_in + LO_FIX);
    else        stage1 = byte_in;
    af_out = lo_hit;
  end

  // step two looks at the output of step one
  always_comb begin
    hi_hit = (stage1 > HI_LIMIT) || cf_in;
    if (hi_hit) byte_out = subtract ? (stage1 - HI_FIX) : (stage1 + HI_FIX);
    else        byte_out = stage1;
    cf_out = hi_hit;
  end
endmodule

// File: rtl/byte_flags.sv
module byte_flags #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] value,
  output logic              parity_even,
  output logic              sign,
  output logic              zero
);
  assign parity_even = ~(^value);
  assign sign        = value[BYTE_W-1];
  assign zero        = (value == '0);
endmodule

// File: rtl/sign_fill.sv
module sign_fill #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] fill
);
  assign fill = {WORD_W{word_in[WORD_W-1]}};
endmodule

// File: rtl/bcd_sext_unit.sv
module bcd_sext_unit
  import adjx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        op,
  input  logic [BYTE_W-1:0] acc_lo,
  input  logic [WORD_W-1:0] acc_word,
  input  logic [FLAG_W-1:0] flag_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] result,
  output logic [FLAG_W-1:0] flag_out
);
  localparam int PAD_W = WORD_W - BYTE_W;

  logic              accept;
  logic              is_sext;
  logic [BYTE_W-1:0] adj_byte;
  logic              adj_af;
  logic              adj_cf;
  logic              f_par;
  logic              f_sign;
  logic              f_zero;
  logic [WORD_W-1:0] fill_word;
  logic [WORD_W-1:0] nxt_result;
  logic [FLAG_W-1:0] nxt_flags;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign is_sext  = (op == OP_SEXT) || (op == OP_SEXT_ALT);

  bcd_correct #(.BYTE_W(BYTE_W)) u_corr (
    .byte_in  (acc_lo),
    .subtract (op == OP_SUB_ADJ),
    .af_in    (flag_in[FL_AF]),
    .cf_in    (flag_in[FL_CF]),
    .byte_out (adj_byte),
    .af_out   (adj_af),
    .cf_out   (adj_cf)
  );

  byte_flags #(.BYTE_W(BYTE_W)) u_flags (
    .value       (adj_byte),
    .parity_even (f_par),
    .sign        (f_sign),
    .zero        (f_zero)
  );

  sign_fill #(.WORD_W(WORD_W)) u_fill (
    .word_in (acc_word),
    .fill    (fill_word)
  );

  always_comb begin
    if (is_sext) begin
      nxt_result = fill_word;
      nxt_flags  = flag_in;
    end else begin
      nxt_result          = {{PAD_W{1'b0}}, adj_byte};
      nxt_flags           = '0;
      nxt_flags[FL_CF]    = adj_cf;
      nxt_flags[FL_PF]    = f_par;
      nxt_flags[FL_AF]    = adj_af;
      nxt_flags[FL_ZF]    = f_zero;
      nxt_flags[FL_SF]    = f_sign;
      nxt_flags[FL_OF]    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_out  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= nxt_result;
      flag_out  <= nxt_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: result is presented one cycle after acceptance
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R8: stalled output holds and blocks input
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(flag_out)));
  p_block_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: reset clears the output stage
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && result == '0 && flag_out == '0));

  // R4: fill word follows the sign of the accepted word
  p_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && is_sext) |=> (result == {WORD_W{$past(acc_word[WORD_W-1])}}));

  // R5: sign extension passes flags through
  p_flags_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && is_sext) |=> (flag_out == $past(flag_in)));

  // R1: an incoming auxiliary carry forces the low correction
  p_af_force_r1: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_sext && flag_in[FL_AF]) |=> flag_out[FL_AF]);

  // R2: an incoming carry forces the high correction
  p_cf_force_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_sext && flag_in[FL_CF]) |=> flag_out[FL_CF]);

  // R6: zero and sign agree with the registered byte
  p_zero_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_sext) |=> (flag_out[FL_ZF] == (result[BYTE_W-1:0] == '0)
                              && flag_out[FL_SF] == result[BYTE_W-1]
                              && result[WORD_W-1:BYTE_W] == '0));
endmodule

// File: tb/bcd_sext_unit_test.sv
module bcd_sext_unit_test;
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] res;
    logic [5:0]  fl;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'd0;
  logic [7:0]  acc_lo = 8'h00;
  logic [15:0] acc_word = 16'h0000;
  logic [5:0]  flag_in = 6'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result;
  logic [5:0]  flag_out;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  bcd_sext_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .acc_lo(acc_lo), .acc_word(acc_word), .flag_in(flag_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .flag_out(flag_out)
  );

  // behavioural reference, flags {OF,SF,ZF,AF,PF,CF}
  function automatic exp_t model(logic [1:0] o, logic [7:0] b, logic [15:0] w, logic [5:0] f);
    exp_t e;
    int   v;
    int   ones;
    bit   a;
    bit   c;
    e.op = o;
    if (o >= 2) begin
      e.res = (w < 16'h8000) ? 16'h0000 : 16'hFFFF;
      e.fl  = f;
      return e;
    end
    v = b; a = 0; c = 0;
    if ((v % 16) > 9 || f[2]) begin
      v = (o == 1) ? v - 6 : v + 6;
      v = (v + 256) % 256;
      a = 1;
    end
    if (v > 'h9F || f[0]) begin
      v = (o == 1) ? v - 'h60 : v + 'h60;
      v = (v + 256) % 256;
      c = 1;
    end
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    e.res = 16'(v);
    e.fl  = {1'b0, (v >= 128), (v == 0), a, ((ones % 2) == 0), c};
    return e;
  endfunction

  task automatic fail_line(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic observe();
    exp_t e;
    logic [5:0] mask;
    string tag;
    n_cmp++;
    if (out_valid !== (q.size() != 0))
      fail_line("R7", "out_valid", 32'(out_valid), 32'(q.size() != 0));
    if (out_valid && q.size() != 0) begin
      e    = q[0];
      mask = (e.op >= 2) ? 6'h3F : 6'h1F;   // overflow is not checked for adjusts
      tag  = (e.op == 0) ? "R1/R2/R6" : (e.op == 1) ? "R3/R6" : "R4/R5";
      n_cmp++;
      if (result !== e.res || (flag_out & mask) !== (e.fl & mask))
        fail_line(tag, "result/flags", {10'd0, flag_out, result}, {10'd0, e.fl & mask, e.res});
    end
    if (out_valid && !out_ready) begin
      n_cmp++;
      if (in_ready !== 1'b0) fail_line("R8", "in_ready while stalled", 32'(in_ready), 32'd0);
    end
  endtask

  task automatic step(bit v, logic [1:0] o, logic [7:0] b, logic [15:0] w, logic [5:0] f, bit rdy);
    @(negedge clk);
    observe();
    in_valid = v; op = o; acc_lo = b; acc_word = w; flag_in = f; out_ready = rdy;
    #1;
    if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
    if (in_valid && in_ready) q.push_back(model(o, b, w, f));
  endtask

  task automatic check_cleared(string when);
    n_cmp++;
    if (out_valid !== 1'b0 || result !== 16'h0000 || flag_out !== 6'h00)
      fail_line("R9", when, {9'd0, out_valid, flag_out, result}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] words [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                               16'h1234, 16'hABCD, 16'h0001, 16'h8001};
    repeat (3) @(negedge clk);
    check_cleared("initial reset");           // R9
    rst = 1'b0;

    // R1 R2 R3 R6: every byte and carry pair, both adjusts, no stall
    for (int o = 0; o < 2; o++)
      for (int fc = 0; fc < 4; fc++)
        for (int b = 0; b < 256; b++)
          step(1, 2'(o), 8'(b), 16'h5A5A,
               {2'(fc >> 1) & 2'b01, 1'b0, 1'(fc >> 1), 1'b0, 1'(fc)}, 1);

    // R4 R5: sign extension with both op codes and arbitrary flags
    for (int i = 0; i < 8; i++)
      for (int o = 2; o < 4; o++)
        step(1, 2'(o), 8'($urandom), words[i], 6'($urandom), 1);

    // R7 R8: random stalls on both sides
    for (int i = 0; i < 400; i++)
      step(($urandom % 3) != 0, 2'($urandom), 8'($urandom), 16'($urandom),
           6'($urandom), ($urandom % 2) == 0);
    step(0, 2'd0, 8'h00, 16'h0000, 6'h00, 1);
    step(0, 2'd0, 8'h00, 16'h0000, 6'h00, 1);

    // R9: reset while a result is stalled
    step(1, 2'd0, 8'h9A, 16'h0000, 6'h00, 0);
    step(0, 2'd0, 8'h00, 16'h0000, 6'h00, 0);
    @(negedge clk);
    observe();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    check_cleared("reset during stall");
    step(0, 2'd0, 8'h00, 16'h0000, 6'h00, 1);
    step(0, 2'd0, 8'h00, 16'h0000, 6'h00, 1);
    finish_run();
  end
endmodule